// File: doc/BRIEF.md
# Two-Wire Serial Register Slave

This block is the serial control port of a larger device. It watches an SCL/SDA pair that has already been resampled into the system clock domain. It answers only to one fixed 7-bit device address. It turns bus transfers into accesses on a plain register-file port: an address, write data, a one-cycle write strobe, and read data returned by the core. SDA is driven open-drain: the block asserts an output enable to pull the line low and reads the line back through an input.

Three transfer shapes are accepted. A single-byte write carries the device address with the write bit, a register address and one data byte. A random read carries the device address with the write bit and a register address, then a repeated start, the device address with the read bit, and one data byte returned by the slave. A current-address read carries only the device address with the read bit and returns the register that an internal pointer selects. Every access leaves the pointer one above the address it used, and the pointer keeps that value across transfers. When a stop ends a transfer that returned read data, the block raises a one-cycle standby request for the power logic.

Top module: `twi_reg_slave`

## Requirements
- R1: The slave answers only when the first 7 bits after a start equal 0x3E, which makes the address byte 0x7C with the write bit (bit 0 = 0) and 0x7D with the read bit (bit 0 = 1). For any other address it never pulls SDA low and issues no write strobe until the next start.
- R2: A falling SDA while SCL is high is a start, and a rising SDA while SCL is high is a stop. A stop returns the slave to idle with SDA released.
- R3: For each byte it accepts (device address, register address, first write data byte), the slave pulls SDA low for the whole of the ninth SCL clock.
- R4: A write of register address A and data D gives exactly one `reg_we` pulse, one cycle long, with `reg_addr` = A and `reg_wdata` = D.
- R5: After any write or read of register A, the pointer holds A+1 modulo 256, so 0xFF is followed by 0x00. The pointer keeps its value across transfers and is 0x00 after reset.
- R6: A random read of A returns the `reg_rdata` value for A, most significant bit first, on eight SCL clocks. The slave then releases SDA for the master's acknowledge clock.
- R7: A current-address read returns the register at the pointer without a register address being sent.
- R8: `standby_req` is a one-cycle pulse after a stop that ends a transfer in which read data was returned. It stays low after a stop that ends a write-only transfer or a transfer that was not addressed to this slave.
- R9: A start seen partway through any byte abandons the transfer under way, writes nothing, and restarts device address reception.
- R10: A second data byte in one write transfer is not acknowledged and not written.
- R11: After reset `sda_oe`, `reg_we` and `standby_req` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| sda_oe | output | 1 | High pulls SDA low |
| reg_addr | output | 8 | Register pointer, which is the access address |
| reg_wdata | output | 8 | Write data for the register file |
| reg_we | output | 1 | One-cycle register write strobe |
| reg_rdata | input | 8 | Register file data at `reg_addr` |
| standby_req | output | 1 | One-cycle standby request |

## Verification
The bench aims at the places where a slave tends to go out of step with the master. If the pointer were updated at the wrong moment or not wrapped, the current-address read after a write to 0xFF would return the wrong register. If the read data were loaded one SCL edge late, or shifted in the wrong order, every random read would come back rotated or reversed. A restart in the middle of a data byte must leave the register file untouched; a slave that kept its bit count would write a spliced byte. Foreign addresses, a second data byte and write-only transfers must each leave SDA undriven and `standby_req` low; a slave that answered anyway would show up as a false acknowledge or a stray standby pulse.

// File: rtl/twi_pkg.sv
package twi_pkg;
  localparam int BYTE_W = 8;
  localparam int CNT_W  = $clog2(BYTE_W);

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_DEV,
    ST_DEV_ACK,
    ST_REG,
    ST_REG_ACK,
    ST_WR,
    ST_WR_ACK,
    ST_RD,
    ST_IGN
  } twi_state_e;
endpackage

// File: rtl/twi_line_sync.sv
module twi_line_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[0] <= RST_VAL;
          else     chain[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[i] <= RST_VAL;
          else     chain[i] <= chain[i-1];
        end
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/twi_bus_cond.sv
module twi_bus_cond #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic bus_start,
  output logic bus_stop
);
  logic scl_s, scl_q, sda_q;

  twi_line_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_scl_sync (
    .clk(clk), .rst(rst), .d(scl_i), .q(scl_s)
  );
  twi_line_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sda_sync (
    .clk(clk), .rst(rst), .d(sda_i), .q(sda_s)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
    end
  end

  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign bus_start = scl_s & scl_q & sda_q & ~sda_s;
  assign bus_stop  = scl_s & scl_q & ~sda_q & sda_s;

  AST_COND_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    $onehot0({bus_start, bus_stop, scl_rise, scl_fall})) else $error("bus events overlap"); // R2
endmodule

// File: rtl/twi_reg_ptr.sv
module twi_reg_ptr #(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ld,
  input  logic [AW-1:0] ld_val,
  input  logic          inc,
  output logic [AW-1:0] ptr
);
  localparam logic [AW-1:0] ONE = {{(AW-1){1'b0}}, 1'b1};

  always_ff @(posedge clk) begin
    if (rst)      ptr <= '0;
    else if (ld)  ptr <= ld_val;
    else if (inc) ptr <= ptr + ONE;
  end

  AST_PTR_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!ld && !inc) |=> $stable(ptr)) else $error("pointer moved"); // R5
endmodule

// File: rtl/twi_slave_ctrl.sv
module twi_slave_ctrl
  import twi_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h3E
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sda_s,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              bus_start,
  input  logic              bus_stop,
  input  logic [BYTE_W-1:0] reg_rdata,
  output logic              sda_oe,
  output logic              reg_we,
  output logic [BYTE_W-1:0] reg_wdata,
  output logic              ptr_ld,
  output logic [BYTE_W-1:0] ptr_val,
  output logic              ptr_inc,
  output logic              standby_req
);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);
  localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

  twi_state_e        state;
  logic [CNT_W-1:0]  cnt;
  logic [BYTE_W-1:0] shreg, tx;
  logic              rw, ack_on, rd_seen;
  logic [BYTE_W-1:0] byte_in;

  assign byte_in = {shreg[BYTE_W-2:0], sda_s};

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_IDLE;
      cnt         <= '0;
      shreg       <= '0;
      tx          <= '0;
      rw          <= 1'b0;
      ack_on      <= 1'b0;
      rd_seen     <= 1'b0;
      sda_oe      <= 1'b0;
      reg_we      <= 1'b0;
      reg_wdata   <= '0;
      ptr_ld      <= 1'b0;
      ptr_val     <= '0;
      ptr_inc     <= 1'b0;
      standby_req <= 1'b0;
    end else begin
      reg_we      <= 1'b0;
      ptr_ld      <= 1'b0;
      ptr_inc     <= 1'b0;
      standby_req <= 1'b0;
      if (bus_start) begin
        state   <= ST_DEV;
        cnt     <= '0;
        ack_on  <= 1'b0;
        sda_oe  <= 1'b0;
        rd_seen <= 1'b0;
      end else if (bus_stop) begin
        state       <= ST_IDLE;
        ack_on      <= 1'b0;
        sda_oe      <= 1'b0;
        standby_req <= rd_seen;
        rd_seen     <= 1'b0;
      end else begin
        case (state)
          ST_DEV, ST_REG, ST_WR: begin
            if (scl_rise) begin
              shreg <= byte_in;
              cnt   <= cnt + CNT_ONE;
              if (cnt == LAST_BIT) begin
                case (state)
                  ST_DEV: begin
                    if (byte_in[BYTE_W-1:1] == DEV_ADDR) begin
                      state <= ST_DEV_ACK;
                      rw    <= byte_in[0];
                    end else begin
                      state <= ST_IGN;
                    end
                  end
                  ST_REG:  state <= ST_REG_ACK;
                  default: state <= ST_WR_ACK;
                endcase
              end
            end
          end
          ST_DEV_ACK, ST_REG_ACK, ST_WR_ACK: begin
            if (scl_fall) begin
              if (!ack_on) begin
                ack_on <= 1'b1;
                sda_oe <= 1'b1;
                if (state == ST_WR_ACK) begin
                  reg_we    <= 1'b1;
                  reg_wdata <= shreg;
                  ptr_inc   <= 1'b1;
                end
              end else begin
                ack_on <= 1'b0;
                sda_oe <= 1'b0;
                cnt    <= '0;
                case (state)
                  ST_DEV_ACK: begin
                    if (rw) begin
                      tx      <= reg_rdata;
                      sda_oe  <= ~reg_rdata[BYTE_W-1];
                      ptr_inc <= 1'b1;
                      rd_seen <= 1'b1;
                      state   <= ST_RD;
                    end else begin
                      state <= ST_REG;
                    end
                  end
                  ST_REG_ACK: begin
                    ptr_ld  <= 1'b1;
                    ptr_val <= shreg;
                    state   <= ST_WR;
                  end
                  default: state <= ST_IGN;
                endcase
              end
            end
          end
          ST_RD: begin
            if (scl_fall) begin
              if (cnt == LAST_BIT) begin
                sda_oe <= 1'b0;
                state  <= ST_IGN;
              end else begin
                cnt    <= cnt + CNT_ONE;
                tx     <= {tx[BYTE_W-2:0], 1'b0};
                sda_oe <= ~tx[BYTE_W-2];
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  AST_OE_WHEN_OWNED: assert property (@(posedge clk) disable iff (rst)
    sda_oe |-> (state inside {ST_DEV_ACK, ST_REG_ACK, ST_WR_ACK, ST_RD})) else $error("SDA driven outside slot"); // R1
  AST_START_RESTART: assert property (@(posedge clk) disable iff (rst)
    bus_start |=> (state == ST_DEV && cnt == '0 && !sda_oe)) else $error("start did not restart"); // R9
  AST_STOP_RELEASE: assert property (@(posedge clk) disable iff (rst)
    bus_stop |=> (state == ST_IDLE && !sda_oe)) else $error("stop did not release"); // R2
  AST_SDA_ON_LOW_SCL: assert property (@(posedge clk) disable iff (rst)
    (sda_oe != $past(sda_oe)) |-> ($past(scl_fall) || $past(bus_start) || $past(bus_stop))) else $error("SDA moved off SCL fall"); // R3
endmodule

// File: rtl/twi_reg_slave.sv
module twi_reg_slave #(
  parameter logic [6:0] DEV_ADDR    = 7'h3E,
  parameter int         SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe,
  output logic [7:0] reg_addr,
  output logic [7:0] reg_wdata,
  output logic       reg_we,
  input  logic [7:0] reg_rdata,
  output logic       standby_req
);
  import twi_pkg::*;

  logic sda_s, scl_rise, scl_fall, bus_start, bus_stop;
  logic ptr_ld, ptr_inc;
  logic [BYTE_W-1:0] ptr_val;

  twi_bus_cond #(.SYNC_STAGES(SYNC_STAGES)) u_cond (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
    .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .bus_start(bus_start), .bus_stop(bus_stop)
  );

  twi_slave_ctrl #(.DEV_ADDR(DEV_ADDR)) u_ctrl (
    .clk(clk), .rst(rst), .sda_s(sda_s), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .bus_start(bus_start), .bus_stop(bus_stop),
    .reg_rdata(reg_rdata), .sda_oe(sda_oe), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .ptr_ld(ptr_ld), .ptr_val(ptr_val),
    .ptr_inc(ptr_inc), .standby_req(standby_req)
  );

  twi_reg_ptr #(.AW(BYTE_W)) u_ptr (
    .clk(clk), .rst(rst), .ld(ptr_ld), .ld_val(ptr_val),
    .inc(ptr_inc), .ptr(reg_addr)
  );

  AST_WE_PULSE: assert property (@(posedge clk) disable iff (rst)
    reg_we |=> !reg_we) else $error("write strobe too long"); // R4
  AST_PTR_ADVANCE: assert property (@(posedge clk) disable iff (rst)
    reg_we |=> (reg_addr == $past(reg_addr) + 8'd1)) else $error("pointer not advanced"); // R5
  AST_STBY_PULSE: assert property (@(posedge clk) disable iff (rst)
    standby_req |=> !standby_req) else $error("standby too long"); // R8
endmodule

// File: tb/twi_reg_slave_tb.sv
module twi_reg_slave_tb;
  localparam int Q = 8;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       scl = 1'b1;
  logic       sda_m = 1'b1;
  logic       sda_oe;
  logic [7:0] reg_addr, reg_wdata, reg_rdata;
  logic       reg_we, standby_req;
  wire        sda_line = sda_m & ~sda_oe;

  logic [7:0] mem [256];
  logic [7:0] exp_mem [256];
  logic [7:0] exp_ptr;
  int wr_cnt = 0, stby_cnt = 0;
  logic [7:0] last_wa, last_wd;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  twi_reg_slave u_dut (
    .clk(clk), .rst(rst), .scl_i(scl), .sda_i(sda_line), .sda_oe(sda_oe),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_we(reg_we),
    .reg_rdata(reg_rdata), .standby_req(standby_req)
  );

  function automatic logic [7:0] init_val(input int i);
    return 8'((i * 37 + 11) & 255);
  endfunction

  assign reg_rdata = mem[reg_addr];

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 256; i++) mem[i] <= init_val(i);
    end else begin
      if (reg_we) begin
        mem[reg_addr] <= reg_wdata;
        last_wa <= reg_addr;
        last_wd <= reg_wdata;
        wr_cnt  <= wr_cnt + 1;
      end
      if (standby_req) stby_cnt <= stby_cnt + 1;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic qwait();
    repeat (Q) @(posedge clk);
    #1;
  endtask

  task automatic bus_start();
    sda_m = 1'b1; qwait();
    scl = 1'b1;   qwait();
    sda_m = 1'b0; qwait();
    scl = 1'b0;   qwait();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; qwait();
    scl = 1'b1;   qwait();
    sda_m = 1'b1; qwait();
    qwait();
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      sda_m = b[i]; qwait();
      scl = 1'b1;   qwait();
      qwait();
      scl = 1'b0;   qwait();
    end
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    send_bits(b, 8);
    sda_m = 1'b1; qwait();
    scl = 1'b1;   qwait();
    ack = ~sda_line;
    qwait();
    scl = 1'b0;   qwait();
  endtask

  task automatic recv_byte(output logic [7:0] b);
    b = '0;
    for (int i = 0; i < 8; i++) begin
      sda_m = 1'b1; qwait();
      scl = 1'b1;   qwait();
      b = {b[6:0], sda_line};
      qwait();
      scl = 1'b0;   qwait();
    end
    sda_m = 1'b1; qwait();
    scl = 1'b1;   qwait();
    chk("R6 released for master ack", int'(sda_line), 1);
    qwait();
    scl = 1'b0;   qwait();
  endtask

  task automatic wr_txn(input logic [7:0] a, input logic [7:0] d);
    logic ack;
    int w0 = wr_cnt, s0 = stby_cnt;
    bus_start();
    send_byte(8'h7C, ack); chk("R3 ack dev write", int'(ack), 1);
    send_byte(a, ack);     chk("R3 ack reg addr", int'(ack), 1);
    send_byte(d, ack);     chk("R3 ack data", int'(ack), 1);
    bus_stop();
    chk("R4 one write", wr_cnt - w0, 1);
    chk("R4 write addr", int'(last_wa), int'(a));
    chk("R4 write data", int'(last_wd), int'(d));
    chk("R8 no standby after write", stby_cnt - s0, 0);
    exp_mem[a] = d;
    exp_ptr = a + 8'd1;
  endtask

  task automatic rd_rand(input logic [7:0] a);
    logic ack;
    logic [7:0] b;
    int s0 = stby_cnt;
    bus_start();
    send_byte(8'h7C, ack); chk("R3 ack dev write", int'(ack), 1);
    send_byte(a, ack);     chk("R3 ack reg addr", int'(ack), 1);
    bus_start();
    send_byte(8'h7D, ack); chk("R1 ack read address", int'(ack), 1);
    recv_byte(b);
    bus_stop();
    chk("R6 random read data", int'(b), int'(exp_mem[a]));
    chk("R8 standby after read", stby_cnt - s0, 1);
    exp_ptr = a + 8'd1;
  endtask

  task automatic rd_cur(input string tag);
    logic ack;
    logic [7:0] b;
    int s0 = stby_cnt;
    bus_start();
    send_byte(8'h7D, ack); chk("R1 ack read address", int'(ack), 1);
    recv_byte(b);
    bus_stop();
    chk(tag, int'(b), int'(exp_mem[exp_ptr]));
    chk("R8 standby after current read", stby_cnt - s0, 1);
    exp_ptr = exp_ptr + 8'd1;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic ack;
    int w0, s0;
    void'($urandom(32'd1234));
    for (int i = 0; i < 256; i++) exp_mem[i] = init_val(i);
    exp_ptr = 8'h00;
    repeat (5) @(posedge clk);
    #1 rst = 1'b0;
    @(posedge clk); #1;
    chk("R11 sda_oe reset", int'(sda_oe), 0);
    chk("R11 reg_we reset", int'(reg_we), 0);
    chk("R11 standby reset", int'(standby_req), 0);
    chk("R5 pointer reset", int'(reg_addr), 0);

    rd_cur("R7 current read after reset");
    wr_txn(8'h21, 8'hA5);
    rd_cur("R7 current read follows write");
    rd_rand(8'h21);
    wr_txn(8'hFF, 8'h3C);
    rd_cur("R5 pointer wraps to 00");

    // R1 foreign address: no ack, no write, no standby
    w0 = wr_cnt; s0 = stby_cnt;
    bus_start();
    send_byte(8'h7E, ack); chk("R1 foreign addr not acked", int'(ack), 0);
    send_byte(8'h10, ack); chk("R1 ignored after mismatch", int'(ack), 0);
    send_byte(8'h55, ack); chk("R1 ignored data", int'(ack), 0);
    bus_stop();
    bus_start();
    send_byte(8'h7F, ack); chk("R1 foreign read not acked", int'(ack), 0);
    bus_stop();
    chk("R1 no write", wr_cnt - w0, 0);
    chk("R8 no standby on foreign", stby_cnt - s0, 0);

    // R10 second data byte
    w0 = wr_cnt;
    bus_start();
    send_byte(8'h7C, ack);
    send_byte(8'h40, ack);
    send_byte(8'h11, ack);
    send_byte(8'h22, ack); chk("R10 second byte not acked", int'(ack), 0);
    bus_stop();
    chk("R10 single write", wr_cnt - w0, 1);
    exp_mem[8'h40] = 8'h11; exp_ptr = 8'h41;
    rd_rand(8'h40);

    // R9 restart inside a data byte
    w0 = wr_cnt;
    bus_start();
    send_byte(8'h7C, ack);
    send_byte(8'h50, ack);
    send_bits(8'hF0, 3);
    chk("R9 nothing written on abort", wr_cnt - w0, 0);
    bus_start();
    send_byte(8'h7C, ack); chk("R9 address after restart", int'(ack), 1);
    send_byte(8'h60, ack);
    send_byte(8'h99, ack);
    bus_stop();
    chk("R9 write after restart", wr_cnt - w0, 1);
    chk("R9 restart write addr", int'(last_wa), 8'h60);
    exp_mem[8'h60] = 8'h99; exp_ptr = 8'h61;
    // R9 restart inside the device address byte
    bus_start();
    send_bits(8'h7C, 4);
    bus_start();
    send_byte(8'h7D, ack); chk("R9 read after address abort", int'(ack), 1);
    begin
      logic [7:0] b;
      recv_byte(b);
      chk("R9 read data after abort", int'(b), int'(exp_mem[exp_ptr]));
    end
    bus_stop();
    exp_ptr = exp_ptr + 8'd1;

    // R2 stop releases mid-transfer
    bus_start();
    send_byte(8'h7C, ack);
    send_bits(8'h33, 5);
    bus_stop();
    chk("R2 idle after stop", int'(sda_oe), 0);

    for (int n = 0; n < 30; n++) begin
      int op = int'($urandom % 3);
      logic [7:0] a = 8'($urandom);
      logic [7:0] d = 8'($urandom);
      if (op == 0) wr_txn(a, d);
      else if (op == 1) rd_rand(a);
      else rd_cur("R7 random current read");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule